// File: doc/BRIEF.md
# Reset Delay Sequencer

This block holds a chip's internal system reset asserted after any reset event and lets it go only after a chain of timed waits has run out. The chain is chosen from two things: whether the event is a power-on (cold) reset or any other (warm) reset, and which class of clock source is selected: an RC or external clock, a crystal, a PLL, or a crystal feeding a PLL. All delay lengths are parameters counted in reference-clock cycles. The one exception is the crystal start-up wait, which counts oscillator periods reported on a pulse input.

A cold chain runs these phases in a fixed order: a power-on wait, then a supply start-up wait, then an oscillator start-up count and a PLL lock wait where the clock source needs them, and finally an internal-state wait. A clock-valid output rises when the clock phases end. The system reset only falls after that. A warm reset runs only the internal-state wait and leaves the clock marked valid. A new request that arrives in the middle of a chain restarts it.

The raw power-on input resets the block asynchronously. Its release is synchronized before counting begins. A lock-failure flag reports a PLL that has not locked within a timeout. The sequencer keeps holding reset until lock is seen.

Top module: `rst_delay_seq`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` and `busy_o` are 1 and `clk_ok_o` and `lock_fail_o` are 0. For an RC or external source (`clk_sel_i` codes 0, 1, 2) with `reg_en_i`=1, `sys_rst_o` falls SYNC_STAGES+T_POR+T_SU_REG+T_RST cycles after `por_i` falls.
- R2: With `reg_en_i`=0, the supply start-up wait lasts T_SU_PWRT cycles instead of T_SU_REG.
- R3: Crystal sources (`clk_sel_i` codes 5, 6, 7) add an oscillator start-up phase. It ends on the OST_EDGES-th cycle in which `osc_edge_i` is high. Without oscillator pulses the chain never moves on.
- R4: PLL sources (`clk_sel_i` codes 3, 4, 7) add a lock phase. It ends at the first cycle in which `pll_lock_i` is high and at least LOCK_CYC cycles of the phase have passed. Code 7 runs the oscillator phase first and then the lock phase.
- R5: `lock_fail_o` rises when the lock phase reaches its LOCK_TMO-th cycle with `pll_lock_i` low. The sequencer keeps waiting for lock. The flag stays set until the next cold chain starts.
- R6: `clk_ok_o` rises at the end of the last clock phase, which is the end of the supply wait for RC and external sources. It rises exactly T_RST cycles before `sys_rst_o` falls. `sys_rst_o` is never 0 while `clk_ok_o` is 0.
- R7: A one-cycle `req_i` with `cause_i` from 1 to 7, made while `clk_ok_o`=1, is a warm reset. `sys_rst_o` is released 1+T_RST cycles after the request cycle, and `clk_ok_o` stays 1 throughout.
- R8: A `req_i` with `cause_i`=0 (power-on cause) starts a full cold chain without the synchronizer stages, and `clk_ok_o` drops at the next clock edge.
- R9: A new `req_i`, or a new pulse on `por_i`, in the middle of a chain restarts the chain from its first phase. The latency is then measured from the new event.
- R10: `busy_o` is 1 exactly while a chain is running. `sys_rst_o` is also 1 in any cycle in which `req_i` is high, even when no chain is running.
- R11: A `req_i` with a warm cause that arrives while `clk_ok_o`=0 starts a full cold chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that all delays are counted in |
| por_i | input | 1 | Raw power-on indication, active high, asynchronous |
| req_i | input | 1 | One-cycle reset request |
| cause_i | input | 3 | Cause of `req_i`: 0 power-on, 1 pin, 2 watchdog, 3 software, 4 illegal opcode, 5 uninitialized register, 6 trap conflict |
| clk_sel_i | input | 3 | Clock source: 0 external, 1 fast RC, 2 low-power RC, 3 external+PLL, 4 fast RC+PLL, 5 crystal, 6 secondary crystal, 7 crystal+PLL |
| reg_en_i | input | 1 | On-chip regulator enabled strap |
| pll_lock_i | input | 1 | PLL lock indication, synchronous to `clk_i` |
| osc_edge_i | input | 1 | High for one cycle per oscillator period, synchronous to `clk_i` |
| sys_rst_o | output | 1 | System reset, active high |
| clk_ok_o | output | 1 | System clock released as valid |
| busy_o | output | 1 | A delay chain is running |
| lock_fail_o | output | 1 | PLL lock timeout seen in the current cold chain |

## Verification
Cold chains are run for every clock-source class and for both regulator straps. The measured release latency tells apart each phase that is added or skipped, and the moment `clk_ok_o` rises separates the clock phases from the internal-state wait. Holding the oscillator pulses low, or holding the lock low past the timeout, shows that progress depends on those inputs and not on elapsed time. The cycle just before and the cycle of the timeout bound the failure flag. Warm requests of every cause, cold requests, requests made while the clock is not yet valid, and requests or power-on pulses made in the middle of a chain separate the warm path, the cold path and the restart behaviour.

// File: rtl/rds_pkg.sv
`timescale 1ns/1ps
package rds_pkg;

   typedef enum logic [2:0] {
      PH_POR   = 3'd0,
      PH_START = 3'd1,
      PH_OST   = 3'd2,
      PH_LOCK  = 3'd3,
      PH_RST   = 3'd4,
      PH_DONE  = 3'd5
   } phase_t;

   localparam logic [2:0] CAUSE_POWER_ON = 3'd0;

   // Clock-source classes: crystal codes need the start-up count,
   // PLL codes need the lock wait.
   function automatic logic needs_ost(input logic [2:0] sel);
      return (sel == 3'd5) || (sel == 3'd6) || (sel == 3'd7);
   endfunction

   function automatic logic needs_pll(input logic [2:0] sel);
      return (sel == 3'd3) || (sel == 3'd4) || (sel == 3'd7);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rds_sync.sv
`timescale 1ns/1ps
module rds_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_i,
   output logic rst_o
);
   logic [STAGES-1:0] q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i) q[i] <= 1'b1;
            else        q[i] <= 1'b0;
         end
      end else begin : g_tail
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i) q[i] <= 1'b1;
            else        q[i] <= q[i-1];
         end
      end
   end

   assign rst_o = q[STAGES-1];
endmodule

// File: rtl/rds_timer.sv
`timescale 1ns/1ps
module rds_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         arst_i,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i)     cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/rds_route.sv
`timescale 1ns/1ps
module rds_route
   import rds_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned T_POR     = 4,
   parameter int unsigned T_SU_REG  = 4,
   parameter int unsigned T_SU_PWRT = 16,
   parameter int unsigned T_RST     = 4
) (
   input  phase_t       ph_i,
   input  logic [2:0]   clk_sel_i,
   input  logic         reg_en_i,
   output phase_t       nxt_o,
   output logic [W-1:0] last_o
);
   logic ost, pll;
   assign ost = needs_ost(clk_sel_i);
   assign pll = needs_pll(clk_sel_i);

   always_comb begin
      nxt_o  = PH_DONE;
      last_o = '0;
      case (ph_i)
         PH_POR: begin
            nxt_o  = PH_START;
            last_o = W'(T_POR - 1);
         end
         PH_START: begin
            nxt_o  = ost ? PH_OST : (pll ? PH_LOCK : PH_RST);
            last_o = reg_en_i ? W'(T_SU_REG - 1) : W'(T_SU_PWRT - 1);
         end
         PH_OST:  nxt_o = pll ? PH_LOCK : PH_RST;
         PH_LOCK: nxt_o = PH_RST;
         PH_RST: begin
            nxt_o  = PH_DONE;
            last_o = W'(T_RST - 1);
         end
         default: nxt_o = PH_DONE;
      endcase
   end
endmodule

// File: rtl/rst_delay_seq.sv
`timescale 1ns/1ps
module rst_delay_seq
   import rds_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned T_POR       = 80,
   parameter int unsigned T_SU_REG    = 160,
   parameter int unsigned T_SU_PWRT   = 512000,
   parameter int unsigned OST_EDGES   = 1024,
   parameter int unsigned LOCK_CYC    = 160,
   parameter int unsigned LOCK_TMO    = 16000,
   parameter int unsigned T_RST       = 160
) (
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       req_i,
   input  logic [2:0] cause_i,
   input  logic [2:0] clk_sel_i,
   input  logic       reg_en_i,
   input  logic       pll_lock_i,
   input  logic       osc_edge_i,
   output logic       sys_rst_o,
   output logic       clk_ok_o,
   output logic       busy_o,
   output logic       lock_fail_o
);
   localparam int unsigned MAXLEN = max2(max2(max2(T_POR, T_SU_REG), max2(T_SU_PWRT, OST_EDGES)),
                                         max2(max2(LOCK_CYC, LOCK_TMO), T_RST));
   localparam int unsigned CW = $clog2(MAXLEN + 1);
   localparam logic [CW-1:0] OST_LAST  = CW'(OST_EDGES - 1);
   localparam logic [CW-1:0] LOCK_MIN  = CW'(LOCK_CYC - 1);
   localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_TMO - 1);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rst_delay_seq: SYNC_STAGES must be at least 2");
   end
   if (T_POR < 1 || T_SU_REG < 1 || T_SU_PWRT < 1 || T_RST < 1 || OST_EDGES < 1 || LOCK_CYC < 1) begin : g_bad_len
      $error("rst_delay_seq: every delay length must be at least 1");
   end
   if (LOCK_TMO <= LOCK_CYC) begin : g_bad_tmo
      $error("rst_delay_seq: LOCK_TMO must exceed LOCK_CYC");
   end

   logic          por_s;
   phase_t        ph_q, nxt;
   logic [CW-1:0] cnt, last;
   logic          inc, adv, clr, cold, clk_ok_q, fail_q;

   rds_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .arst_i (por_i),
      .rst_o  (por_s)
   );

   rds_route #(
      .W(CW), .T_POR(T_POR), .T_SU_REG(T_SU_REG), .T_SU_PWRT(T_SU_PWRT), .T_RST(T_RST)
   ) u_route (
      .ph_i      (ph_q),
      .clk_sel_i (clk_sel_i),
      .reg_en_i  (reg_en_i),
      .nxt_o     (nxt),
      .last_o    (last)
   );

   rds_timer #(.W(CW)) u_timer (
      .clk_i  (clk_i),
      .arst_i (por_s),
      .clr_i  (clr),
      .inc_i  (inc),
      .cnt_o  (cnt)
   );

   always_comb begin
      inc = 1'b0;
      adv = 1'b0;
      case (ph_q)
         PH_POR, PH_START, PH_RST: begin
            inc = 1'b1;
            adv = (cnt == last);
         end
         PH_OST: begin
            inc = osc_edge_i;
            adv = osc_edge_i && (cnt == OST_LAST);
         end
         PH_LOCK: begin
            inc = (cnt != LOCK_LAST);
            adv = pll_lock_i && (cnt >= LOCK_MIN);
         end
         default: ;
      endcase
   end

   // Cold restart for power-on causes, or whenever the clock is not yet valid.
   assign cold = (cause_i == CAUSE_POWER_ON) || !clk_ok_q;
   assign clr  = req_i || adv;

   always_ff @(posedge clk_i or posedge por_s) begin
      if (por_s) begin
         ph_q     <= PH_POR;
         clk_ok_q <= 1'b0;
         fail_q   <= 1'b0;
      end else if (req_i) begin
         if (cold) begin
            ph_q     <= PH_POR;
            clk_ok_q <= 1'b0;
            fail_q   <= 1'b0;
         end else begin
            ph_q <= PH_RST;
         end
      end else if (adv) begin
         ph_q <= nxt;
         if (nxt == PH_RST) clk_ok_q <= 1'b1;
      end else if (ph_q == PH_LOCK && cnt == LOCK_LAST && !pll_lock_i) begin
         fail_q <= 1'b1;
      end
   end

   assign busy_o      = (ph_q != PH_DONE);
   assign sys_rst_o   = req_i || (ph_q != PH_DONE);
   assign clk_ok_o    = clk_ok_q;
   assign lock_fail_o = fail_q;
endmodule

// File: rtl/rds_checker.sv
`timescale 1ns/1ps
module rds_checker (
   input logic       clk_i,
   input logic       por_i,
   input logic       req_i,
   input logic [2:0] cause_i,
   input logic       pll_lock_i,
   input logic       sys_rst_o,
   input logic       clk_ok_o,
   input logic       busy_o,
   input logic       lock_fail_o
);
   assert_hold_without_clock_R6: assert property (@(posedge clk_i) disable iff (por_i)
      !clk_ok_o |-> sys_rst_o);

   assert_release_order_R6: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(sys_rst_o) |-> (clk_ok_o && !busy_o));

   assert_busy_in_reset_R10: assert property (@(posedge clk_i) disable iff (por_i)
      busy_o |-> sys_rst_o);

   assert_warm_keeps_clock_R7: assert property (@(posedge clk_i) disable iff (por_i)
      (req_i && cause_i != 3'd0 && clk_ok_o) |=> (clk_ok_o && busy_o && sys_rst_o));

   assert_cold_drops_clock_R8: assert property (@(posedge clk_i) disable iff (por_i)
      (req_i && cause_i == 3'd0) |=> (!clk_ok_o && busy_o));

   assert_fail_without_lock_R5: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(lock_fail_o) |-> !$past(pll_lock_i));
endmodule

bind rst_delay_seq rds_checker u_chk (.*);

// File: tb/rst_delay_seq_test.sv
`timescale 1ns/1ps
module rst_delay_seq_test;
   localparam int SYNC = 2, TP = 3, TSR = 4, TSP = 20, OST = 8, LC = 5, LT = 30, TR = 6;

   logic clk = 1'b0;
   logic por_i = 1'b1, req_i = 1'b0, reg_en_i = 1'b1, pll_lock_i = 1'b0, osc_edge_i = 1'b0;
   logic [2:0] cause_i = 3'd0, clk_sel_i = 3'd1;
   logic sys_rst_o, clk_ok_o, busy_o, lock_fail_o;
   int errs = 0, checks = 0;

   always #4 clk = ~clk;

   rst_delay_seq #(
      .SYNC_STAGES(SYNC), .T_POR(TP), .T_SU_REG(TSR), .T_SU_PWRT(TSP),
      .OST_EDGES(OST), .LOCK_CYC(LC), .LOCK_TMO(LT), .T_RST(TR)
   ) uut (
      .clk_i(clk), .por_i(por_i), .req_i(req_i), .cause_i(cause_i),
      .clk_sel_i(clk_sel_i), .reg_en_i(reg_en_i), .pll_lock_i(pll_lock_i),
      .osc_edge_i(osc_edge_i), .sys_rst_o(sys_rst_o), .clk_ok_o(clk_ok_o),
      .busy_o(busy_o), .lock_fail_o(lock_fail_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // Counts negedges after the trigger until sys_rst_o is low.
   task automatic measure(input bit drop_req, output int rst_lat, output int ok_lat, output bit ok_low);
      rst_lat = -1; ok_lat = -1; ok_low = 1'b0;
      for (int k = 1; k <= 2000; k++) begin
         @(negedge clk);
         if (!clk_ok_o) ok_low = 1'b1;
         if (ok_lat < 0 && clk_ok_o) ok_lat = k;
         if (!sys_rst_o) begin
            rst_lat = k;
            break;
         end
         if (k == 1 && drop_req) req_i = 1'b0;
      end
   endtask

   task automatic start_por(input logic [2:0] sel, input logic reg_en, input logic osc, input logic lock);
      @(negedge clk);
      clk_sel_i = sel; reg_en_i = reg_en; osc_edge_i = osc; pll_lock_i = lock; por_i = 1'b1;
      repeat (3) @(negedge clk);
      por_i = 1'b0;
   endtask

   task automatic cold_chain(input string tag, input logic [2:0] sel, input logic reg_en,
                             input logic osc, input logic lock, input int exp_ok, input int exp_rst);
      int r, o; bit lo;
      start_por(sel, reg_en, osc, lock);
      measure(1'b0, r, o, lo);
      check({tag, " clk_ok latency"}, o, exp_ok);
      check({tag, " release latency"}, r, exp_rst);
   endtask

   task automatic t_reset_state;
      repeat (4) @(negedge clk);
      check("R1 reset sys_rst", sys_rst_o, 1);
      check("R1 reset clk_ok", clk_ok_o, 0);
      check("R10 reset busy", busy_o, 1);
      check("R1 reset lock_fail", lock_fail_o, 0);
   endtask

   task automatic t_sources;
      cold_chain("R1 fast RC", 3'd1, 1'b1, 1'b0, 1'b0, SYNC+TP+TSR, SYNC+TP+TSR+TR);
      cold_chain("R1 low-power RC", 3'd2, 1'b1, 1'b0, 1'b0, SYNC+TP+TSR, SYNC+TP+TSR+TR);
      cold_chain("R2 regulator off", 3'd0, 1'b0, 1'b0, 1'b0, SYNC+TP+TSP, SYNC+TP+TSP+TR);
      cold_chain("R3 crystal", 3'd5, 1'b1, 1'b1, 1'b0, SYNC+TP+TSR+OST, SYNC+TP+TSR+OST+TR);
      cold_chain("R3 secondary crystal", 3'd6, 1'b1, 1'b1, 1'b0, SYNC+TP+TSR+OST, SYNC+TP+TSR+OST+TR);
      cold_chain("R4 ext PLL", 3'd3, 1'b1, 1'b0, 1'b1, SYNC+TP+TSR+LC, SYNC+TP+TSR+LC+TR);
      cold_chain("R4 crystal PLL", 3'd7, 1'b1, 1'b1, 1'b1, SYNC+TP+TSR+OST+LC, SYNC+TP+TSR+OST+LC+TR);
   endtask

   task automatic t_ost_stall;
      int r, o; bit lo;
      start_por(3'd5, 1'b1, 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      check("R3 stalled without osc sys_rst", sys_rst_o, 1);
      check("R3 stalled without osc clk_ok", clk_ok_o, 0);
      osc_edge_i = 1'b1;
      measure(1'b0, r, o, lo);
      check("R3 osc resumed clk_ok latency", o, OST);
      check("R6 osc resumed release latency", r, OST + TR);
   endtask

   task automatic t_lock_timeout;
      int r, o; bit lo;
      start_por(3'd4, 1'b1, 1'b0, 1'b0);
      // lock phase entered at edge SYNC+TP+TSR; timeout flagged LT cycles later
      repeat (SYNC+TP+TSR+LT-1) @(negedge clk);
      check("R5 flag before timeout", lock_fail_o, 0);
      @(negedge clk);
      check("R5 flag at timeout", lock_fail_o, 1);
      repeat (10) @(negedge clk);
      check("R5 still holding sys_rst", sys_rst_o, 1);
      check("R5 still no clk_ok", clk_ok_o, 0);
      pll_lock_i = 1'b1;
      measure(1'b0, r, o, lo);
      check("R4 late lock clk_ok latency", o, 1);
      check("R4 late lock release latency", r, 1 + TR);
      check("R5 flag sticky after lock", lock_fail_o, 1);
      cold_chain("R5 new cold chain", 3'd1, 1'b1, 1'b0, 1'b1, SYNC+TP+TSR, SYNC+TP+TSR+TR);
      check("R5 flag cleared by cold chain", lock_fail_o, 0);
   endtask

   task automatic t_warm;
      int r, o; bit lo;
      for (int c = 1; c <= 7; c++) begin
         @(negedge clk);
         cause_i = 3'(c); req_i = 1'b1;
         #1;
         check("R10 sys_rst during request cycle", sys_rst_o, 1);
         check("R10 busy idle during request cycle", busy_o, 0);
         measure(1'b1, r, o, lo);
         check($sformatf("R7 warm cause %0d release", c), r, 1 + TR);
         check($sformatf("R7 warm cause %0d clk_ok kept", c), lo, 0);
      end
   endtask

   task automatic t_cold_req;
      int r, o; bit lo;
      @(negedge clk);
      clk_sel_i = 3'd1; cause_i = 3'd0; req_i = 1'b1;
      measure(1'b1, r, o, lo);
      check("R8 cold request clk_ok dropped", lo, 1);
      check("R8 cold request clk_ok latency", o, 1+TP+TSR);
      check("R8 cold request release", r, 1+TP+TSR+TR);
   endtask

   task automatic t_restart;
      int r, o; bit lo;
      @(negedge clk);
      cause_i = 3'd1; req_i = 1'b1;
      @(negedge clk); req_i = 1'b0;
      @(negedge clk);
      check("R10 busy mid warm chain", busy_o, 1);
      @(negedge clk);
      cause_i = 3'd3; req_i = 1'b1;
      measure(1'b1, r, o, lo);
      check("R9 warm restart release", r, 1 + TR);
      start_por(3'd7, 1'b1, 1'b1, 1'b1);
      repeat (10) @(negedge clk);
      por_i = 1'b1;
      @(negedge clk);
      por_i = 1'b0;
      measure(1'b0, r, o, lo);
      check("R9 power-on restart clk_ok", o, SYNC+TP+TSR+OST+LC);
      check("R9 power-on restart release", r, SYNC+TP+TSR+OST+LC+TR);
   endtask

   task automatic t_warm_unstable;
      int r, o; bit lo;
      start_por(3'd5, 1'b1, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      check("R11 clock not valid before request", clk_ok_o, 0);
      cause_i = 3'd4; req_i = 1'b1; osc_edge_i = 1'b1;
      measure(1'b1, r, o, lo);
      check("R11 full chain clk_ok", o, 1+TP+TSR+OST);
      check("R11 full chain release", r, 1+TP+TSR+OST+TR);
   endtask

   initial begin
      t_reset_state();
      t_sources();
      t_ost_stall();
      t_lock_timeout();
      t_warm();
      t_cold_req();
      t_restart();
      t_warm_unstable();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errs++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule